// File: doc/BRIEF.md
# Compressed Segment Allocation Controller

This block keeps the segment table of one set of a compressed last-level cache and updates it on misses and writes. The data array of the set is cut into fixed-size segments, for example 16 bytes each. Each segment carries a valid bit and a back pointer. The back pointer names the superblock tag slot that owns the segment, the line of that superblock the data belongs to, and the segment's position in the line's compressed data. Because the segments of a line are found by matching back pointers, they can sit anywhere in the set. The block therefore never has to compact a set to open a contiguous hole.

The block takes one command at a time through a valid/ready handshake. There are four commands: drop a whole superblock, drop one line, fill a new line, and change the compressed size of a line that is already present. The choice of victim comes from outside the block. A freed segment that belongs to a dirty line is strobed out with its index, one per cycle, so the data path can write it back. Free segments are granted lowest index first, and up to four of them are granted in a single cycle. The read data path uses the back-pointer outputs to find and order a line's segments on a hit.

Top module: `seg_alloc_ctrl`

## Requirements
- R1: When reset is asserted, every segment becomes invalid, `cmd_ready_o` is high, and `done_o`, `miss_o`, `wb_valid_o` and `alloc_mask_o` are all low.
- R2: Command code 0 (superblock drop) releases every valid segment whose owner tag equals `tag_i`, whatever its line. Segments of other tags stay valid.
- R3: Command code 1 (line drop) releases only the segments whose owner tag equals `tag_i` and whose line equals `line_i`. Other lines of the same tag stay valid.
- R4: Each released segment whose line has its bit set in `dirty_i` (bit k stands for line k of the addressed superblock) gets exactly one `wb_valid_o` cycle carrying its index in `wb_seg_o`. These strobes come one per cycle, in ascending index order, while the segment is still valid, and its valid bit clears at the end of that cycle. Segments of clean lines produce no strobe.
- R5: Command code 2 (fill) with size code c (0..3) allocates c+1 segments, and code 3 means uncompressed. Any segments already held by that line are first released without writeback. The segments granted are the lowest-index free ones, with positions 0..c in ascending index order and the back pointer set to `tag_i`/`line_i`. When nothing has to be released, `done_o` comes in the first cycle after acceptance.
- R6: Command code 3 (resize) to a size of n = c+1 segments on a line that holds m < n segments adds n-m of the lowest-index free segments, with positions m..n-1. The segments already held are untouched.
- R7: A resize to n segments on a line that holds m >= n segments releases the segments in positions n and above, without writeback, and adds none.
- R8: If a fill or a grow needs more segments than will be free, `miss_o` is raised together with `done_o`, and line `victim_line_i` of the same tag is released first, under the writeback rule of R4. If the segments are still too few after that, nothing is allocated.
- R9: A command is taken only on a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` stays low from acceptance through the single `done_o` cycle, and `cmd_valid_i` has no effect in that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_i | input | 2 | 0 superblock drop, 1 line drop, 2 fill, 3 resize |
| tag_i | input | TAG_W | Superblock tag slot addressed |
| line_i | input | LINE_W | Line within the superblock |
| size_i | input | SEQ_W | Compressed size code, segments minus one |
| victim_line_i | input | LINE_W | Line of the same superblock to drop on shortage |
| dirty_i | input | LINES_PER_SB | Dirty state of each line of the addressed superblock |
| done_o | output | 1 | Last cycle of a command |
| miss_o | output | 1 | With done_o: the command ran short of free segments |
| alloc_mask_o | output | NUM_SEG | Segments granted in this cycle |
| wb_valid_o | output | 1 | Writeback strobe for a freed dirty segment |
| wb_seg_o | output | SEG_W | Index of the segment being written back |
| seg_valid_o | output | NUM_SEG | Segment valid bits |
| bp_tag_o | output | NUM_SEG*TAG_W | Owner tag slot of each segment |
| bp_line_o | output | NUM_SEG*LINE_W | Owner line of each segment |
| bp_seq_o | output | NUM_SEG*SEQ_W | Position of each segment within its line |

## Verification
The bench builds the block with eight segments, four tag slots, four lines per superblock and lines of up to four segments. With only eight segments, two four-segment lines fill the set, so the shortage path is reachable in a short sequence. That path covers both a victim that frees enough room and a victim that owns nothing. The small set also makes it easy to scatter a line's segments across non-adjacent indices, to check that positions follow index order when a line grows into low holes, and to produce a burst of four writebacks from one victim.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

  typedef enum logic [1:0] {
    CMD_EVICT_SB   = 2'd0,
    CMD_EVICT_LINE = 2'd1,
    CMD_FILL       = 2'd2,
    CMD_RESIZE     = 2'd3
  } seg_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FREE  = 2'd1,
    ST_ALLOC = 2'd2
  } seg_state_e;

endpackage

// File: rtl/sa_bp_match.sv
module sa_bp_match #(
  parameter int NUM_SEG = 16,
  parameter int TAG_W   = 2,
  parameter int LINE_W  = 2,
  parameter int SEQ_W   = 2
) (
  input  logic [NUM_SEG-1:0]        valid_i,
  input  logic [NUM_SEG*TAG_W-1:0]  bp_tag_i,
  input  logic [NUM_SEG*LINE_W-1:0] bp_line_i,
  input  logic [NUM_SEG*SEQ_W-1:0]  bp_seq_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [LINE_W-1:0]         line_i,
  input  logic [LINE_W-1:0]         victim_i,
  input  logic [SEQ_W-1:0]          size_i,
  output logic [NUM_SEG-1:0]        tag_hit_o,
  output logic [NUM_SEG-1:0]        line_hit_o,
  output logic [NUM_SEG-1:0]        victim_hit_o,
  output logic [NUM_SEG-1:0]        tail_hit_o
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic t_eq;
    assign t_eq            = valid_i[s] && (bp_tag_i[s*TAG_W +: TAG_W] == tag_i);
    assign tag_hit_o[s]    = t_eq;
    assign line_hit_o[s]   = t_eq && (bp_line_i[s*LINE_W +: LINE_W] == line_i);
    assign victim_hit_o[s] = t_eq && (bp_line_i[s*LINE_W +: LINE_W] == victim_i);
    // position beyond the new last segment
    assign tail_hit_o[s]   = line_hit_o[s] && (bp_seq_i[s*SEQ_W +: SEQ_W] > size_i);
  end

endmodule

// File: rtl/sa_free_pick.sv
module sa_free_pick #(
  parameter int NUM_SEG = 16,
  parameter int SEQ_W   = 2,
  localparam int NEED_W = SEQ_W + 1
) (
  input  logic [NUM_SEG-1:0]       free_i,
  input  logic [NEED_W-1:0]        need_i,
  input  logic [SEQ_W-1:0]         base_i,
  output logic [NUM_SEG-1:0]       pick_o,
  output logic [NUM_SEG*SEQ_W-1:0] seq_o,
  output logic                     ok_o
);

  always_comb begin
    logic [NEED_W-1:0] cnt;
    cnt    = '0;
    pick_o = '0;
    seq_o  = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (free_i[s] && (cnt < need_i)) begin
        pick_o[s]               = 1'b1;
        seq_o[s*SEQ_W +: SEQ_W] = base_i + cnt[SEQ_W-1:0];
        cnt                     = cnt + NEED_W'(1);
      end
    end
    ok_o = (cnt == need_i);
  end

endmodule

// File: rtl/sa_first_one.sv
module sa_first_one #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
    any_o = |vec_i;
  end

endmodule

// File: rtl/seg_alloc_ctrl.sv
module seg_alloc_ctrl
  import seg_alloc_pkg::*;
#(
  parameter int NUM_SEG      = 16,
  parameter int NUM_TAGS     = 4,
  parameter int LINES_PER_SB = 4,
  parameter int MAX_SEGS     = 4,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int TAG_W  = $clog2(NUM_TAGS),
  localparam int LINE_W = $clog2(LINES_PER_SB),
  localparam int SEQ_W  = $clog2(MAX_SEGS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  output logic                        cmd_ready_o,
  input  logic [1:0]                  cmd_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [LINE_W-1:0]           line_i,
  input  logic [SEQ_W-1:0]            size_i,
  input  logic [LINE_W-1:0]           victim_line_i,
  input  logic [LINES_PER_SB-1:0]     dirty_i,
  output logic                        done_o,
  output logic                        miss_o,
  output logic [NUM_SEG-1:0]          alloc_mask_o,
  output logic                        wb_valid_o,
  output logic [SEG_W-1:0]            wb_seg_o,
  output logic [NUM_SEG-1:0]          seg_valid_o,
  output logic [NUM_SEG*TAG_W-1:0]    bp_tag_o,
  output logic [NUM_SEG*LINE_W-1:0]   bp_line_o,
  output logic [NUM_SEG*SEQ_W-1:0]    bp_seq_o
);

  localparam int NEED_W = SEQ_W + 1;
  localparam int CNT_W  = $clog2(NUM_SEG + 1);
  localparam int CMP_W  = CNT_W + 1;

  seg_state_e state_q;

  logic [NUM_SEG-1:0] valid_q;
  logic [TAG_W-1:0]   bp_tag_q  [NUM_SEG];
  logic [LINE_W-1:0]  bp_line_q [NUM_SEG];
  logic [SEQ_W-1:0]   bp_seq_q  [NUM_SEG];

  logic [NUM_SEG-1:0] rel_q, wb_q;
  logic [NEED_W-1:0]  need_q;
  logic [SEQ_W-1:0]   base_q;
  logic [TAG_W-1:0]   tag_q;
  logic [LINE_W-1:0]  line_q;
  logic               miss_q;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_flat
    assign bp_tag_o[s*TAG_W +: TAG_W]    = bp_tag_q[s];
    assign bp_line_o[s*LINE_W +: LINE_W] = bp_line_q[s];
    assign bp_seq_o[s*SEQ_W +: SEQ_W]    = bp_seq_q[s];
  end
  assign seg_valid_o = valid_q;

  function automatic logic [CNT_W-1:0] popcnt(input logic [NUM_SEG-1:0] v);
    popcnt = '0;
    for (int i = 0; i < NUM_SEG; i++) popcnt = popcnt + CNT_W'(v[i]);
  endfunction

  // back-pointer match against the incoming command
  logic [NUM_SEG-1:0] tag_hit, line_hit, victim_hit, tail_hit;

  sa_bp_match #(
    .NUM_SEG (NUM_SEG),
    .TAG_W   (TAG_W),
    .LINE_W  (LINE_W),
    .SEQ_W   (SEQ_W)
  ) u_match (
    .valid_i      (valid_q),
    .bp_tag_i     (bp_tag_o),
    .bp_line_i    (bp_line_o),
    .bp_seq_i     (bp_seq_o),
    .tag_i        (tag_i),
    .line_i       (line_i),
    .victim_i     (victim_line_i),
    .size_i       (size_i),
    .tag_hit_o    (tag_hit),
    .line_hit_o   (line_hit),
    .victim_hit_o (victim_hit),
    .tail_hit_o   (tail_hit)
  );

  // command decode at acceptance
  logic [NUM_SEG-1:0] acc_rel, acc_wb;
  logic [NEED_W-1:0]  acc_need;
  logic [SEQ_W-1:0]   acc_base;
  logic               acc_miss;

  always_comb begin
    logic [CNT_W-1:0]  cur_cnt, free_cnt;
    logic [NEED_W-1:0] n_segs;
    logic [CMP_W-1:0]  avail;
    cur_cnt  = popcnt(line_hit);
    free_cnt = popcnt(~valid_q);
    n_segs   = NEED_W'(size_i) + NEED_W'(1);
    avail    = CMP_W'(free_cnt);
    acc_rel  = '0;
    acc_wb   = '0;
    acc_need = '0;
    acc_base = '0;
    acc_miss = 1'b0;
    unique case (seg_cmd_e'(cmd_i))
      CMD_EVICT_SB: begin
        acc_rel = tag_hit;
        for (int s = 0; s < NUM_SEG; s++)
          acc_wb[s] = tag_hit[s] && dirty_i[bp_line_q[s]];
      end
      CMD_EVICT_LINE: begin
        acc_rel = line_hit;
        acc_wb  = dirty_i[line_i] ? line_hit : '0;
      end
      CMD_FILL: begin
        acc_rel  = line_hit;
        acc_need = n_segs;
        avail    = CMP_W'(free_cnt) + CMP_W'(cur_cnt);
      end
      CMD_RESIZE: begin
        if (CMP_W'(n_segs) > CMP_W'(cur_cnt)) begin
          acc_need = n_segs - cur_cnt[NEED_W-1:0];
          acc_base = cur_cnt[SEQ_W-1:0];
        end else begin
          acc_rel = tail_hit;
        end
      end
      default: ;
    endcase
    // shortage: drop the supplied victim line of the same superblock
    if (CMP_W'(acc_need) > avail) begin
      acc_miss = 1'b1;
      acc_rel  = acc_rel | victim_hit;
      if (dirty_i[victim_line_i]) acc_wb = acc_wb | victim_hit;
    end
  end

  // writeback sequencing
  logic [SEG_W-1:0] wb_idx;
  logic             wb_any;

  sa_first_one #(
    .N (NUM_SEG),
    .W (SEG_W)
  ) u_wb_pick (
    .vec_i (wb_q),
    .idx_o (wb_idx),
    .any_o (wb_any)
  );

  // free segment grant
  logic [NUM_SEG-1:0]       pick;
  logic [NUM_SEG*SEQ_W-1:0] pick_seq;
  logic                     pick_ok;

  sa_free_pick #(
    .NUM_SEG (NUM_SEG),
    .SEQ_W   (SEQ_W)
  ) u_free_pick (
    .free_i (~valid_q),
    .need_i (need_q),
    .base_i (base_q),
    .pick_o (pick),
    .seq_o  (pick_seq),
    .ok_o   (pick_ok)
  );

  assign cmd_ready_o  = (state_q == ST_IDLE);
  assign wb_valid_o   = (state_q == ST_FREE) && wb_any;
  assign wb_seg_o     = wb_idx;
  assign alloc_mask_o = ((state_q == ST_ALLOC) && pick_ok) ? pick : '0;
  assign done_o       = (state_q == ST_ALLOC) ||
                        ((state_q == ST_FREE) && !wb_any && (need_q == '0));
  assign miss_o       = done_o && miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= '0;
      rel_q   <= '0;
      wb_q    <= '0;
      need_q  <= '0;
      base_q  <= '0;
      tag_q   <= '0;
      line_q  <= '0;
      miss_q  <= 1'b0;
      for (int s = 0; s < NUM_SEG; s++) begin
        bp_tag_q[s]  <= '0;
        bp_line_q[s] <= '0;
        bp_seq_q[s]  <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            rel_q   <= acc_rel;
            wb_q    <= acc_wb;
            need_q  <= acc_need;
            base_q  <= acc_base;
            tag_q   <= tag_i;
            line_q  <= line_i;
            miss_q  <= acc_miss;
            state_q <= ((acc_rel == '0) && (acc_need != '0)) ? ST_ALLOC : ST_FREE;
          end
        end
        ST_FREE: begin
          if (wb_any) begin
            valid_q[wb_idx] <= 1'b0;
            wb_q[wb_idx]    <= 1'b0;
            rel_q[wb_idx]   <= 1'b0;
          end else begin
            valid_q <= valid_q & ~rel_q;
            rel_q   <= '0;
            state_q <= (need_q != '0) ? ST_ALLOC : ST_IDLE;
          end
        end
        ST_ALLOC: begin
          if (pick_ok) begin
            for (int s = 0; s < NUM_SEG; s++) begin
              if (pick[s]) begin
                valid_q[s]   <= 1'b1;
                bp_tag_q[s]  <= tag_q;
                bp_line_q[s] <= line_q;
                bp_seq_q[s]  <= pick_seq[s*SEQ_W +: SEQ_W];
              end
            end
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: strobed segment is still live, and gone one cycle later
  a_r4_wb_seg_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> valid_q[wb_seg_o]);
  a_r4_wb_seg_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !valid_q[$past(wb_seg_o)]);
  // R5: grants only free segments, at most MAX_SEGS, and they become valid
  a_r5_grant_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|alloc_mask_o) |-> ((alloc_mask_o & valid_q) == '0));
  a_r5_grant_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(alloc_mask_o) <= MAX_SEGS);
  a_r5_grant_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|alloc_mask_o) |=> ((valid_q & $past(alloc_mask_o)) == $past(alloc_mask_o)));
  // R8: miss only reported on completion
  a_r8_miss_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> done_o);
  // R9: busy through done, done lasts one cycle
  a_r9_busy_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_ready_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && cmd_ready_o));
  a_r4_no_wb_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!wb_valid_o && (alloc_mask_o == '0)));

endmodule

// File: tb/sim_seg_alloc_ctrl.sv
module sim_seg_alloc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS  = 8;
  localparam int NT  = 4;
  localparam int LPS = 4;
  localparam int MS  = 4;
  localparam int SGW = $clog2(NS);
  localparam int TW  = $clog2(NT);
  localparam int LW  = $clog2(LPS);
  localparam int QW  = $clog2(MS);
  localparam int NV  = 14;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [1:0] cmd_i = '0;
  logic [TW-1:0] tag_i = '0;
  logic [LW-1:0] line_i = '0;
  logic [QW-1:0] size_i = '0;
  logic [LW-1:0] victim_line_i = '0;
  logic [LPS-1:0] dirty_i = '0;
  logic cmd_ready_o, done_o, miss_o, wb_valid_o;
  logic [NS-1:0] alloc_mask_o, seg_valid_o;
  logic [SGW-1:0] wb_seg_o;
  logic [NS*TW-1:0] bp_tag_o;
  logic [NS*LW-1:0] bp_line_o;
  logic [NS*QW-1:0] bp_seq_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_alloc_ctrl #(
    .NUM_SEG(NS), .NUM_TAGS(NT), .LINES_PER_SB(LPS), .MAX_SEGS(MS)
  ) u0 (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_i, .tag_i, .line_i,
    .size_i, .victim_line_i, .dirty_i, .done_o, .miss_o, .alloc_mask_o,
    .wb_valid_o, .wb_seg_o, .seg_valid_o, .bp_tag_o, .bp_line_o, .bp_seq_o
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  // cmd tag line size victim dirty | valid alloc miss wb_cnt wb_first wb_last
  localparam logic [39:0] VEC [NV] = '{
    {2'd2,2'd0,2'd0,2'd3,2'd0,4'b0000, 8'h0F,8'h0F,1'b0,3'd0,3'd0,3'd0},
    {2'd2,2'd1,2'd0,2'd1,2'd0,4'b0000, 8'h3F,8'h30,1'b0,3'd0,3'd0,3'd0},
    {2'd2,2'd1,2'd1,2'd0,2'd0,4'b0000, 8'h7F,8'h40,1'b0,3'd0,3'd0,3'd0},
    {2'd3,2'd0,2'd0,2'd1,2'd0,4'b0000, 8'h73,8'h00,1'b0,3'd0,3'd0,3'd0},
    {2'd3,2'd1,2'd1,2'd2,2'd0,4'b0000, 8'h7F,8'h0C,1'b0,3'd0,3'd0,3'd0},
    {2'd1,2'd1,2'd0,2'd0,2'd0,4'b0001, 8'h4F,8'h00,1'b0,3'd2,3'd4,3'd5},
    {2'd3,2'd0,2'd0,2'd3,2'd0,4'b0000, 8'h7F,8'h30,1'b0,3'd0,3'd0,3'd0},
    {2'd3,2'd1,2'd1,2'd3,2'd0,4'b0000, 8'hFF,8'h80,1'b0,3'd0,3'd0,3'd0},
    {2'd2,2'd1,2'd2,2'd0,2'd1,4'b0010, 8'h37,8'h04,1'b1,3'd4,3'd2,3'd7},
    {2'd0,2'd0,2'd0,2'd0,2'd0,4'b0000, 8'h04,8'h00,1'b0,3'd0,3'd0,3'd0},
    {2'd2,2'd3,2'd0,2'd3,2'd0,4'b0000, 8'h1F,8'h1B,1'b0,3'd0,3'd0,3'd0},
    {2'd2,2'd3,2'd1,2'd3,2'd2,4'b0000, 8'h1F,8'h00,1'b1,3'd0,3'd0,3'd0},
    {2'd0,2'd1,2'd0,2'd0,2'd0,4'b0100, 8'h1B,8'h00,1'b0,3'd1,3'd2,3'd2},
    {2'd2,2'd3,2'd0,2'd0,2'd0,4'b0000, 8'h01,8'h01,1'b0,3'd0,3'd0,3'd0}
  };

  function automatic string req_of(input int i);
    case (i)
      3:        return "R7";
      4, 6, 7:  return "R6";
      5:        return "R3";
      8, 11:    return "R8";
      9, 12:    return "R2";
      default:  return "R5";
    endcase
  endfunction

  logic [NS-1:0] got_alloc;
  logic got_miss;
  int got_wb, wb_first, wb_last, got_cyc;

  task automatic run_cmd(input logic [1:0] c, input logic [TW-1:0] t,
                         input logic [LW-1:0] l, input logic [QW-1:0] s,
                         input logic [LW-1:0] v, input logic [LPS-1:0] d);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = c; tag_i = t; line_i = l;
    size_i = s; victim_line_i = v; dirty_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    got_alloc = '0; got_miss = 1'b0; got_wb = 0; wb_first = 0; wb_last = 0; got_cyc = 0;
    for (int k = 0; k < 40; k++) begin
      got_cyc++;
      chk(!cmd_ready_o, "R9", "ready while busy", int'(cmd_ready_o), 0);
      if (wb_valid_o) begin
        chk(seg_valid_o[wb_seg_o], "R4", "segment live during writeback", 0, 1);
        if (got_wb == 0) wb_first = int'(wb_seg_o);
        else chk(int'(wb_seg_o) > wb_last, "R4", "writeback order", int'(wb_seg_o), wb_last + 1);
        wb_last = int'(wb_seg_o);
        got_wb++;
      end
      if (done_o) begin
        got_alloc = alloc_mask_o;
        got_miss  = miss_o;
        break;
      end
      @(negedge clk_i);
    end
    @(negedge clk_i);
  endtask

  function automatic int bp_field(input int s, input int which);
    case (which)
      0:       return int'(bp_tag_o[s*TW +: TW]);
      1:       return int'(bp_line_o[s*LW +: LW]);
      default: return int'(bp_seq_o[s*QW +: QW]);
    endcase
  endfunction

  task automatic chk_bp(input int s, input int t, input int l, input int q, input string r);
    chk(bp_field(s, 0) == t, r, $sformatf("seg%0d tag", s), bp_field(s, 0), t);
    chk(bp_field(s, 1) == l, r, $sformatf("seg%0d line", s), bp_field(s, 1), l);
    chk(bp_field(s, 2) == q, r, $sformatf("seg%0d position", s), bp_field(s, 2), q);
  endtask

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 1);
    chk(seg_valid_o == '0, "R1", "valid in reset", int'(seg_valid_o), 0);
    chk(cmd_ready_o && !done_o && !miss_o && !wb_valid_o && alloc_mask_o == '0,
        "R1", "outputs in reset", int'({cmd_ready_o, done_o, miss_o, wb_valid_o}), 8);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      string r;
      v = VEC[i];
      r = req_of(i);
      run_cmd(v[39:38], v[37:36], v[35:34], v[33:32], v[31:30], v[29:26]);
      chk(seg_valid_o == v[25:18], r, $sformatf("step%0d valid", i), int'(seg_valid_o), int'(v[25:18]));
      chk(got_alloc == v[17:10], r, $sformatf("step%0d grant", i), int'(got_alloc), int'(v[17:10]));
      chk(got_miss == v[9], "R8", $sformatf("step%0d miss", i), int'(got_miss), int'(v[9]));
      chk(got_wb == int'(v[8:6]), "R4", $sformatf("step%0d writebacks", i), got_wb, int'(v[8:6]));
      if (v[8:6] != 0) begin
        chk(wb_first == int'(v[5:3]), "R4", $sformatf("step%0d first wb", i), wb_first, int'(v[5:3]));
        chk(wb_last == int'(v[2:0]), "R4", $sformatf("step%0d last wb", i), wb_last, int'(v[2:0]));
      end
      if (i == 0) chk(got_cyc == 1, "R5", "single-cycle grant", got_cyc, 1);
      if (i == 0) chk_bp(3, 0, 0, 3, "R5");
      if (i == 4) begin
        chk_bp(2, 1, 1, 1, "R6");
        chk_bp(3, 1, 1, 2, "R6");
        chk_bp(6, 1, 1, 0, "R6");
      end
      if (i == 7) chk_bp(7, 1, 1, 3, "R6");
      if (i == 8) chk_bp(2, 1, 2, 0, "R8");
      if (i == 10) chk_bp(3, 3, 0, 2, "R5");
    end

    // R9: request during a busy command is ignored
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = 2'd0; tag_i = 2'd3; line_i = '0;
    size_i = '0; victim_line_i = '0; dirty_i = 4'b0001;
    @(negedge clk_i);
    cmd_i = 2'd2; tag_i = 2'd0; size_i = 2'd3; dirty_i = '0;
    chk(!cmd_ready_o, "R9", "busy after accept", int'(cmd_ready_o), 0);
    chk(wb_valid_o && wb_seg_o == '0, "R4", "dirty drop strobe", int'(wb_seg_o), 0);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(done_o, "R9", "done after strobe", int'(done_o), 1);
    @(negedge clk_i);
    chk(cmd_ready_o, "R9", "ready after done", int'(cmd_ready_o), 1);
    repeat (3) @(negedge clk_i);
    chk(seg_valid_o == '0, "R9", "busy request had no effect", int'(seg_valid_o), 0);

    // R1: reset clears a populated table
    run_cmd(2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 4'b0000);
    chk(seg_valid_o == 8'h03, "R5", "refill before reset", int'(seg_valid_o), 3);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(seg_valid_o == '0 && cmd_ready_o, "R1", "async reset clears", int'(seg_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && alloc_mask_o == '0, "R1", "quiet after reset", int'(done_o), 0);
    report();
  end

endmodule